// File: doc/BRIEF.md
# Bus Access Probe Target

This block is a register-mapped target on a simple 32-bit memory bus with per-byte lane enables. Software uses it to confirm that its byte, halfword and word stores reach a device intact. Software writes a test number into a select byte. The block then reports three values for that test: the access width to use, the byte offset to hit, and the value to store. After the store, software reads back a counter to see whether the write arrived with the right lanes and the right data.

The block holds four built-in tests, numbered 0 to 3. Any higher number reports an unsupported width code, so software can step upward through the numbers until it reaches that code. A fixed ASCII name, ending in a null byte, is readable from the header for identification. Reads return one cycle after the request. The bus carries word addresses inside a window of at most 4 KiB.

Top module: `bus_probe_top`

## Requirements
- R1: After reset the selected test is 0, the write counter is 0 and the read-valid output is low.
- R2: A read request gives `busRValid` high with its data exactly one cycle later. `busRValid` is low in every cycle that does not follow a read request.
- R3: Word 0 reads as zero in bits 7:0 and 31:16, with the width code of the selected test in bits 15:8. A write to word 0 with lane 0 enabled loads `busWData[7:0]` as the test number. A write to word 0 without lane 0 enabled leaves the test number unchanged.
- R4: All registers are little endian, with byte lane 0 in bits 7:0. Word 1 returns the test's byte offset and word 2 returns its data value. The table is:
  - test 0: width 1, offset 0x101, data 0xA5
  - test 1: width 2, offset 0x202, data 0xBEEF
  - test 2: width 4, offset 0x304, data 0x12345678
  - test 3: width 1, offset 0x403, data 0x3C
- R5: Test numbers 4 to 255 read back width 0, offset 0 and data 0, and no write increments the counter while such a number is selected.
- R6: A write increments the counter (word 3) by one when all of the following hold:
  - its word address equals offset/4;
  - its lane enables equal the width mask shifted left by offset mod 4 (width 1 gives mask 0001, width 2 gives 0011, width 4 gives 1111);
  - its enabled lanes carry the data value shifted left by 8 times (offset mod 4).
  Lanes that are not enabled are don't-care.
- R7: A write that is wrong in address, lanes or data does not change the counter. A write to the width, offset, data, counter or name registers has no effect.
- R8: Any write that loads the test number also clears the counter.
- R9: The counter saturates at its all-ones value for `COUNT_W` bits. It is read zero-extended to 32 bits.
- R10: Words 4 and 5 return the name "BUSPROBE" as little-endian bytes (0x50535542, 0x45424F52), and word 6 returns zero as the terminator. Every other word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Request valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | WORD_AW (10) | Word address within the window |
| busByteEn | input | 4 | Byte lane enables for writes |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data |
| busRValid | output | 1 | Read data valid |

## Verification
A write takes effect at the clock edge that accepts it. Read data is registered, so it appears one cycle after its request. A read of the counter issued in the cycle after a write therefore shows that write, and its result is due one cycle later again. The bench queues the expected value of every read when it issues the request. A monitor pops that value in the falling-edge half of the cycle in which `busRValid` is high. Any stray, missing or late response therefore shows up as an unexpected pop or as entries left in the queue.

// File: rtl/bus_probe_pkg.sv
package bus_probe_pkg;

  typedef struct packed {
    logic [7:0]  width;
    logic [31:0] offset;
    logic [31:0] data;
  } testDescT;

  typedef enum logic [2:0] {
    REG_HDR, REG_OFF, REG_DATA, REG_CNT, REG_NAME0, REG_NAME1, REG_ZERO
  } regSelT;

  typedef struct packed {
    logic   selWrite;
    logic   hitWrite;
    logic   rdEn;
    regSelT rdReg;
  } strobeT;

  localparam logic [31:0] NAME_WORD0 = "PSUB";
  localparam logic [31:0] NAME_WORD1 = "EBOR";

  function automatic testDescT lookupTest(input logic [7:0] sel);
    testDescT d;
    case (sel)
      8'd0:    d = '{width: 8'd1, offset: 32'h101, data: 32'hA5};
      8'd1:    d = '{width: 8'd2, offset: 32'h202, data: 32'hBEEF};
      8'd2:    d = '{width: 8'd4, offset: 32'h304, data: 32'h12345678};
      8'd3:    d = '{width: 8'd1, offset: 32'h403, data: 32'h3C};
      default: d = '{width: 8'd0, offset: 32'h0, data: 32'h0};
    endcase
    return d;
  endfunction

  function automatic logic [3:0] laneMaskOf(input testDescT d);
    logic [3:0] base;
    case (d.width)
      8'd1:    base = 4'b0001;
      8'd2:    base = 4'b0011;
      8'd4:    base = 4'b1111;
      default: base = 4'b0000;
    endcase
    return base << d.offset[1:0];
  endfunction

endpackage

// File: rtl/bus_probe_ctrl.sv
module bus_probe_ctrl
  import bus_probe_pkg::*;
#(
  parameter int WORD_AW = 10
) (
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [WORD_AW-1:0] busWordAddr,
  input  logic [3:0]         busByteEn,
  input  logic [31:0]        busWData,
  input  testDescT           curTest,
  output strobeT             strobes
);

  logic [3:0]  expMask;
  logic [31:0] laneBits;
  logic [31:0] expLaneData;
  logic        addrHit;
  logic        wrReq;

  assign wrReq   = busValid && busWrite;
  assign expMask = laneMaskOf(curTest);
  assign addrHit = (curTest.offset[31:2] == {{(30-WORD_AW){1'b0}}, busWordAddr});
  assign expLaneData = curTest.data << {curTest.offset[1:0], 3'b000};

  generate
    for (genvar lane = 0; lane < 4; lane++) begin : g_lane
      assign laneBits[lane*8 +: 8] = {8{busByteEn[lane]}};
    end
  endgenerate

  always_comb begin
    strobes.selWrite = wrReq && (busWordAddr == '0) && busByteEn[0];
    strobes.hitWrite = wrReq && (expMask != 4'b0000) && addrHit &&
                       (busByteEn == expMask) &&
                       ((busWData & laneBits) == expLaneData);
    strobes.rdEn     = busValid && !busWrite;
    case (busWordAddr)
      WORD_AW'(0): strobes.rdReg = REG_HDR;
      WORD_AW'(1): strobes.rdReg = REG_OFF;
      WORD_AW'(2): strobes.rdReg = REG_DATA;
      WORD_AW'(3): strobes.rdReg = REG_CNT;
      WORD_AW'(4): strobes.rdReg = REG_NAME0;
      WORD_AW'(5): strobes.rdReg = REG_NAME1;
      default:     strobes.rdReg = REG_ZERO;
    endcase
  end

endmodule

// File: rtl/bus_probe_dp.sv
module bus_probe_dp
  import bus_probe_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobes,
  input  logic [7:0]         selData,
  output testDescT           curTest,
  output logic [7:0]         testSelQ,
  output logic [COUNT_W-1:0] countQ,
  output logic [31:0]        rdDataQ,
  output logic               rdValidQ
);

  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  logic [31:0] rdMux;

  assign curTest = lookupTest(testSelQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testSelQ <= 8'd0;
      countQ   <= '0;
    end else if (strobes.selWrite) begin
      testSelQ <= selData;
      countQ   <= '0;
    end else if (strobes.hitWrite && (countQ != CNT_MAX)) begin
      countQ   <= countQ + 1'b1;
    end
  end

  always_comb begin
    case (strobes.rdReg)
      REG_HDR:   rdMux = {16'h0, curTest.width, 8'h0};
      REG_OFF:   rdMux = curTest.offset;
      REG_DATA:  rdMux = curTest.data;
      REG_CNT:   rdMux = 32'(countQ);
      REG_NAME0: rdMux = NAME_WORD0;
      REG_NAME1: rdMux = NAME_WORD1;
      default:   rdMux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= 32'h0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobes.rdEn;
      if (strobes.rdEn) rdDataQ <= rdMux;
    end
  end

endmodule

// File: rtl/bus_probe_top.sv
module bus_probe_top
  import bus_probe_pkg::*;
#(
  parameter int WORD_AW = 10,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [WORD_AW-1:0] busWordAddr,
  input  logic [3:0]         busByteEn,
  input  logic [31:0]        busWData,
  output logic [31:0]        busRData,
  output logic               busRValid
);

  strobeT             strobes;
  testDescT           curTest;
  logic [7:0]         testSelQ;
  logic [COUNT_W-1:0] countQ;

  bus_probe_ctrl #(.WORD_AW(WORD_AW)) u_ctrl (
    .busValid    (busValid),
    .busWrite    (busWrite),
    .busWordAddr (busWordAddr),
    .busByteEn   (busByteEn),
    .busWData    (busWData),
    .curTest     (curTest),
    .strobes     (strobes)
  );

  bus_probe_dp #(.COUNT_W(COUNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .selData  (busWData[7:0]),
    .curTest  (curTest),
    .testSelQ (testSelQ),
    .countQ   (countQ),
    .rdDataQ  (busRData),
    .rdValidQ (busRValid)
  );

endmodule

// File: rtl/bus_probe_chk.sv
module bus_probe_chk #(
  parameter int WORD_AW = 10,
  parameter int COUNT_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [WORD_AW-1:0] busWordAddr,
  input logic [3:0]         busByteEn,
  input logic               busRValid,
  input logic [7:0]         testSelQ,
  input logic [COUNT_W-1:0] countQ
);

  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  logic selW;
  assign selW = busValid && busWrite && (busWordAddr == '0) && busByteEn[0];

  p_read_due_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> busRValid);

  p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> !busRValid);

  p_select_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    selW |=> (countQ == '0));

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == CNT_MAX && !selW) |=> (countQ == CNT_MAX));

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    !selW |=> (countQ == $past(countQ)) ||
              (countQ == COUNT_W'($past(countQ) + 1'b1)));

  p_unsupported_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (testSelQ > 8'd3 && !selW) |=> $stable(countQ));

  p_select_only_lane0_r3: assert property (@(posedge clk) disable iff (!rstN)
    !selW |=> $stable(testSelQ));

endmodule

bind bus_probe_top bus_probe_chk #(.WORD_AW(WORD_AW), .COUNT_W(COUNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busValid    (busValid),
  .busWrite    (busWrite),
  .busWordAddr (busWordAddr),
  .busByteEn   (busByteEn),
  .busRValid   (busRValid),
  .testSelQ    (testSelQ),
  .countQ      (countQ)
);

// File: tb/bus_probe_top_tb.sv
module bus_probe_top_tb;

  localparam int WORD_AW = 10;
  localparam int COUNT_W = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busValid = 1'b0;
  logic               busWrite = 1'b0;
  logic [WORD_AW-1:0] busWordAddr = '0;
  logic [3:0]         busByteEn = '0;
  logic [31:0]        busWData = '0;
  logic [31:0]        busRData;
  logic               busRValid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  bus_probe_top #(.WORD_AW(WORD_AW), .COUNT_W(COUNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busByteEn(busByteEn), .busWData(busWData),
    .busRData(busRData), .busRValid(busRValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] addr, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busWordAddr = addr[11:2];
    busByteEn = be; busWData = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busWordAddr = addr[11:2]; busByteEn = 4'h0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busValid = 1'b0;
  endtask

  // Monitor: rvalid rises at the edge after the request; compare mid-cycle.
  always @(negedge clk) begin
    if (rstN && busRValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected read response 0x%08h expected none", busRData);
      end else begin
        check(tagQ.pop_front(), busRData, expQ.pop_front());
      end
    end
  end

  task automatic finishRun();
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d responses missing expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rvalid after reset", {31'b0, busRValid}, 32'h0);
    rstN = 1'b1;
    // R1/R3/R4 reset state, test 0
    rd(12'h000, 32'h0000_0100, "R1 R3 header width test0");
    rd(12'h00C, 32'h0, "R1 counter zero");
    rd(12'h004, 32'h101, "R4 offset test0");
    rd(12'h008, 32'hA5, "R4 data test0");
    // R6 matching byte write at lane 1
    wr(12'h100, 4'b0010, 32'h0000_A500);
    rd(12'h00C, 32'h1, "R6 byte hit counted");
    // R7 mismatches and read-only writes
    wr(12'h100, 4'b0001, 32'h0000_00A5);
    wr(12'h100, 4'b0010, 32'h0000_A600);
    wr(12'h104, 4'b0010, 32'h0000_A500);
    wr(12'h00C, 4'b1111, 32'hFFFF_FFFF);
    rd(12'h00C, 32'h1, "R7 mismatches ignored");
    wr(12'h004, 4'b1111, 32'h0000_0000);
    rd(12'h004, 32'h101, "R7 offset reg read-only");
    // R3 word 0 write without lane 0 leaves selection
    wr(12'h000, 4'b0010, 32'h0000_0200);
    rd(12'h000, 32'h0000_0100, "R3 no lane0 no select");
    // R8 select test 1 clears count
    wr(12'h000, 4'b0001, 32'h1);
    rd(12'h00C, 32'h0, "R8 select clears counter");
    rd(12'h000, 32'h0000_0200, "R4 width test1");
    rd(12'h004, 32'h202, "R4 offset test1");
    rd(12'h008, 32'hBEEF, "R4 data test1");
    wr(12'h200, 4'b1100, 32'hBEEF_0000);
    wr(12'h200, 4'b1100, 32'hBEEF_1234);
    wr(12'h200, 4'b0100, 32'h00EF_0000);
    rd(12'h00C, 32'h2, "R6 halfword hits, don't-care lanes");
    // R9 saturation on test 2
    wr(12'h000, 4'b0001, 32'h2);
    rd(12'h000, 32'h0000_0400, "R4 width test2");
    rd(12'h008, 32'h1234_5678, "R4 data test2");
    for (int i = 0; i < 9; i++) wr(12'h304, 4'b1111, 32'h1234_5678);
    rd(12'h00C, 32'h7, "R9 counter saturates");
    // test 3
    wr(12'h000, 4'b0001, 32'h3);
    rd(12'h004, 32'h403, "R4 offset test3");
    rd(12'h008, 32'h3C, "R4 data test3");
    wr(12'h400, 4'b1000, 32'h3C00_0000);
    rd(12'h00C, 32'h1, "R6 byte hit lane 3");
    // R5 unsupported numbers
    wr(12'h000, 4'b0001, 32'h7);
    rd(12'h000, 32'h0, "R5 width code unsupported");
    rd(12'h004, 32'h0, "R5 offset zero");
    rd(12'h008, 32'h0, "R5 data zero");
    wr(12'h400, 4'b1000, 32'h3C00_0000);
    wr(12'h000, 4'b0001, 32'h0);
    wr(12'h000, 4'b0001, 32'hFF);
    wr(12'h100, 4'b0010, 32'h0000_A500);
    rd(12'h00C, 32'h0, "R5 no counting when unsupported");
    // R10 name and unused words
    rd(12'h010, 32'h5053_5542, "R10 name word 0");
    rd(12'h014, 32'h4542_4F52, "R10 name word 1");
    rd(12'h018, 32'h0, "R10 terminator");
    rd(12'h020, 32'h0, "R10 unused word");
    rd(12'hFFC, 32'h0, "R10 last word");
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule